// File: doc/BRIEF.md
# Bus Error Status Capture Register

This block records why the most recent local-bus transfer made by a DMA master ended with a transfer-error acknowledge. Each acknowledge comes with a 2-bit cause code. The block keeps one sticky flag for each of three known causes: local time-out, failed access to the remote system bus, and memory parity failure. Every new error replaces all three flags, so at most one flag is ever set. An error whose cause is not one of the three known causes leaves all flags clear. Software reads the flags through a byte-wide register port and clears them by writing a self-clearing bit in the same byte.

The block also holds a few read-only configuration bytes. These are loaded from external jumper and strap pins while reset is held. Once reset is released they no longer follow the pins, and writes to them finish normally without changing their contents.

The register port is single-cycle. It takes an address, a write enable and a write byte. Read data is registered and returned with one cycle of latency.

Top module: `busErrCapture`

## Requirements
- R1: An error strobe with cause code 1 (local time-out) sets the time-out flag (status bit 5) and clears the remote and parity flags on the same clock edge.
- R2: An error strobe with cause code 2 (remote bus) sets the remote flag (status bit 6) and clears the time-out and parity flags.
- R3: An error strobe with cause code 3 (parity) sets the parity flag (status bit 7) and clears the time-out and remote flags.
- R4: An error strobe with cause code 0 (unrecognised source) clears all three flags. The cause input is ignored whenever the strobe is low.
- R5: A write to address 0 with bit 4 set clears all three flags. A write to address 0 with bit 4 clear leaves the flags unchanged.
- R6: If an error strobe and a clearing write happen in the same cycle, the error wins and its flag is set.
- R7: The status byte at address 0 reads bit 4 (the clear bit) and bits 3..0 as 0 at all times.
- R8: After reset, all flags read 0 and the read data output is 0.
- R9: Configuration byte k (k = 0..NUM_CFG-1) is read at address k+1 and returns strapIn[8k+7:8k] as sampled during reset. After reset it ignores changes on strapIn.
- R10: Writes to configuration addresses complete but do not change the configuration bytes or the flags.
- R11: Addresses above NUM_CFG read as 0.
- R12: regRdData shows the value at the address presented before a clock edge one cycle later, after that edge, and holds its old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; while high, the configuration bytes load from strapIn |
| errStrobe | input | 1 | Transfer-error acknowledge seen this cycle |
| errCause | input | 2 | Cause code: 0 other, 1 time-out, 2 remote bus, 3 parity |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Write enable for the register port |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Registered read data byte |
| strapIn | input | 8*NUM_CFG | Jumper and strap inputs, captured during reset |

## Verification
A flag that is wrong inside the block shows up at regRdData on the first status read after the error or write that caused it, one cycle after the address is presented. Its bit position tells which cause was mishandled. The most likely faults each leave a visible trace in the status byte. One is a priority inversion between a clearing write and an error in the same cycle, which leaves the byte at 0 instead of the new flag. Another is an accumulating flag register, which leaves more than one bit set. A third is a clear decoded on the wrong bit, which leaves the flag standing after the write. A configuration byte that follows the pins after reset, or that accepts writes, shows up on the next read of that address.

// File: rtl/busErrPkg.sv
package busErrPkg;

  typedef enum logic [1:0] {
    CAUSE_OTHER   = 2'd0,
    CAUSE_TIMEOUT = 2'd1,
    CAUSE_REMOTE  = 2'd2,
    CAUSE_PARITY  = 2'd3
  } errCause_e;

  localparam int BYTE_W  = 8;
  localparam int FLAG_W  = 3;
  localparam int CLR_BIT = 4;   // self-clearing write-one bit in the status byte

  // flag vector order: [2] parity, [1] remote, [0] time-out -> status bits 7..5
  typedef struct packed {
    logic              capture;   // error strobe seen, load newFlags
    logic [FLAG_W-1:0] newFlags;  // decoded one-hot (or zero) flag image
    logic              swClear;   // software clear write
  } flagCtrl_t;

endpackage

// File: rtl/busErrCtrl.sv
module busErrCtrl
  import busErrPkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NUM_CFG = 3,
  localparam int IDX_W  = $clog2(NUM_CFG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              errStrobe,
  input  logic [1:0]        errCause,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  output flagCtrl_t         ctl,
  output logic              rdMapped,
  output logic [IDX_W-1:0]  rdIdx
);

  errCause_e causeCode;
  logic      statusHit;

  assign causeCode = errCause_e'(errCause);
  assign statusHit = (regAddr == '0);

  always_comb begin
    ctl = '0;
    ctl.capture = errStrobe;
    if (errStrobe) begin
      unique case (causeCode)
        CAUSE_TIMEOUT: ctl.newFlags = 3'b001;
        CAUSE_REMOTE:  ctl.newFlags = 3'b010;
        CAUSE_PARITY:  ctl.newFlags = 3'b100;
        default:       ctl.newFlags = 3'b000;
      endcase
    end
    ctl.swClear = regWrEn && statusHit && regWrData[CLR_BIT];
  end

  assign rdMapped = (int'(regAddr) <= NUM_CFG);
  assign rdIdx    = regAddr[IDX_W-1:0];

  // R1..R4: the decoded image never names more than one source
  p_decode_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl.newFlags));

  // R5: a write with the clear bit low never asks for a clear
  p_no_clear_on_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && !regWrData[CLR_BIT]) |-> !ctl.swClear);

endmodule

// File: rtl/busErrDatapath.sv
module busErrDatapath
  import busErrPkg::*;
#(
  parameter int NUM_CFG = 3,
  localparam int IDX_W  = $clog2(NUM_CFG + 1),
  localparam int STRAP_W = NUM_CFG * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  flagCtrl_t          ctl,
  input  logic               rdMapped,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [FLAG_W-1:0]  flagsQ,
  output logic [BYTE_W-1:0]  rdData
);

  logic [BYTE_W-1:0] cfgQ [NUM_CFG];
  logic [BYTE_W-1:0] statusByte;
  logic [BYTE_W-1:0] rdNext;

  // error capture has priority over the software clear
  always_ff @(posedge clk) begin
    if (rst)              flagsQ <= '0;
    else if (ctl.capture) flagsQ <= ctl.newFlags;
    else if (ctl.swClear) flagsQ <= '0;
  end

  // configuration bytes follow the straps only while reset is held
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) cfgQ[g] <= strapIn[g*BYTE_W +: BYTE_W];
    end

    // R9/R10: frozen once reset is gone
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(cfgQ[g]));
  end

  assign statusByte = {flagsQ, 1'b0, 4'b0000};

  always_comb begin
    rdNext = '0;
    if (rdMapped) begin
      if (rdIdx == '0) rdNext = statusByte;
      for (int k = 0; k < NUM_CFG; k++) begin
        if (int'(rdIdx) == k + 1) rdNext = cfgQ[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else     rdData <= rdNext;
  end

  // R6: a capture always lands, whatever the clear request
  p_capture_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |=> flagsQ == $past(ctl.newFlags));

endmodule

// File: rtl/busErrCapture.sv
module busErrCapture
  import busErrPkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NUM_CFG = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      errStrobe,
  input  logic [1:0]                errCause,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic                      regWrEn,
  input  logic [7:0]                regWrData,
  output logic [7:0]                regRdData,
  input  logic [NUM_CFG*8-1:0]      strapIn
);

  localparam int IDX_W = $clog2(NUM_CFG + 1);

  flagCtrl_t         ctl;
  logic              rdMapped;
  logic [IDX_W-1:0]  rdIdx;
  logic [FLAG_W-1:0] flags;

  busErrCtrl #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) ctrl_i (
    .clk(clk), .rst(rst), .errStrobe(errStrobe), .errCause(errCause),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .ctl(ctl), .rdMapped(rdMapped), .rdIdx(rdIdx)
  );

  busErrDatapath #(.NUM_CFG(NUM_CFG)) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .rdMapped(rdMapped), .rdIdx(rdIdx),
    .strapIn(strapIn), .flagsQ(flags), .rdData(regRdData)
  );

  p_timeout_r1: assert property (@(posedge clk) disable iff (rst)
    (errStrobe && errCause == 2'd1) |=> flags == 3'b001);

  p_remote_r2: assert property (@(posedge clk) disable iff (rst)
    (errStrobe && errCause == 2'd2) |=> flags == 3'b010);

  p_parity_r3: assert property (@(posedge clk) disable iff (rst)
    (errStrobe && errCause == 2'd3) |=> flags == 3'b100);

  p_other_r4: assert property (@(posedge clk) disable iff (rst)
    (errStrobe && errCause == 2'd0) |=> flags == 3'b000);

  p_sw_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (!errStrobe && regWrEn && regAddr == '0 && regWrData[4]) |=> flags == 3'b000);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!errStrobe && !(regWrEn && regAddr == '0)) |=> $stable(flags));

  p_low_bits_r7: assert property (@(posedge clk) disable iff (rst)
    $past(regAddr) == '0 |-> regRdData[4:0] == 5'b0);

  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    (int'(regAddr) > NUM_CFG) |=> regRdData == 8'h00);

  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    regAddr == '0 |=> regRdData[7:5] == $past(flags));

endmodule

// File: tb/busErrCapture_tb.sv
module busErrCapture_tb_top;

  localparam int ADDR_W  = 3;
  localparam int NUM_CFG = 3;
  localparam logic [23:0] STRAP_VAL = 24'h5A_C3_81;

  logic              clk = 1'b0;
  logic              rst;
  logic              errStrobe;
  logic [1:0]        errCause;
  logic [ADDR_W-1:0] regAddr;
  logic              regWrEn;
  logic [7:0]        regWrData;
  logic [7:0]        regRdData;
  logic [23:0]       strapIn;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  busErrCapture #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) dut_i (
    .clk(clk), .rst(rst), .errStrobe(errStrobe), .errCause(errCause),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .strapIn(strapIn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    @(negedge clk);
    d = regRdData;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic err(input logic [1:0] c);
    @(negedge clk);
    errStrobe = 1'b1; errCause = c;
    @(negedge clk);
    errStrobe = 1'b0; errCause = 2'd0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R8 rdData after reset", regRdData, 8'h00);
    rd(0, d); chk("R8 flags after reset", d, 8'h00);
  endtask

  task automatic t_sources();
    logic [7:0] d;
    err(2'd3); rd(0, d); chk("R3 parity", d, 8'h80);
    err(2'd1); rd(0, d); chk("R1 time-out replaces parity", d, 8'h20);
    err(2'd2); rd(0, d); chk("R2 remote replaces time-out", d, 8'h40);
    err(2'd3); rd(0, d); chk("R3 parity replaces remote", d, 8'h80);
    err(2'd0); rd(0, d); chk("R4 other clears all", d, 8'h00);
    // cause ignored without strobe
    err(2'd2);
    @(negedge clk); errCause = 2'd1;
    @(negedge clk); errCause = 2'd0;
    rd(0, d); chk("R4 cause ignored without strobe", d, 8'h40);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    err(2'd1);
    wr(0, 8'hEF); rd(0, d); chk("R5 write without clear bit", d, 8'h20);
    wr(0, 8'h10); rd(0, d); chk("R5 write-one clears", d, 8'h00);
    err(2'd3);
    wr(0, 8'hFF); rd(0, d); chk("R7 clear bit reads 0 after clear", d, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    err(2'd3);
    @(negedge clk);
    errStrobe = 1'b1; errCause = 2'd2;
    regAddr = 0; regWrEn = 1'b1; regWrData = 8'h10;
    @(negedge clk);
    errStrobe = 1'b0; errCause = 2'd0; regWrEn = 1'b0; regWrData = 8'h00;
    rd(0, d); chk("R6 error wins over clear", d, 8'h40);
    chk("R7 low bits zero with flag set", d & 8'h1F, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] d;
    strapIn = 24'h00_00_00;
    for (int k = 0; k < NUM_CFG; k++) begin
      rd(ADDR_W'(k + 1), d);
      chk("R9 config byte", d, STRAP_VAL[k*8 +: 8]);
    end
    wr(2, 8'hFF); rd(2, d); chk("R10 config write ignored", d, 8'hC3);
    rd(0, d); chk("R10 flags untouched by config write", d, 8'h40);
    rd(4, d); chk("R11 unmapped 4", d, 8'h00);
    rd(7, d); chk("R11 unmapped 7", d, 8'h00);
  endtask

  task automatic t_latency();
    logic [7:0] d;
    rd(0, d); chk("R12 status before switch", d, 8'h40);
    @(negedge clk);
    regAddr = 3;
    #1 chk("R12 holds before edge", regRdData, 8'h40);
    @(negedge clk);
    chk("R12 new data after one edge", regRdData, 8'h5A);
  endtask

  task automatic run_all();
    t_reset();
    t_sources();
    t_clear();
    t_collision();
    t_config();
    t_latency();
  endtask

  initial begin
    bit timedOut = 1'b0;
    rst = 1'b1; errStrobe = 1'b0; errCause = 2'd0;
    regAddr = '0; regWrEn = 1'b0; regWrData = 8'h00;
    strapIn = STRAP_VAL;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule